// File: doc/BRIEF.md
# Saturating Add/Subtract Execution Unit

This unit sits in the execute stage of a 32-bit processor. Each cycle it can accept one instruction word together with two signed operands already read from the register file. From the instruction word it extracts the condition code, a two-bit operation selector and three register indices. It then computes one of four saturating results:

- plain add
- plain subtract
- add of a doubled operand
- subtract of a doubled operand

The doubled forms clamp the doubled operand before it is used. Their final sum or difference is then clamped a second time, on its own.

The result, the destination index and a write enable are registered and appear one clock after the input strobe. A condition-pass input gates execution. An instruction whose condition fails writes nothing and leaves the status unchanged. Whenever a value is clamped, a sticky saturation bit in a status word is set. Only reset clears it.

Top module: `qsat_unit`

## Requirements
- R1: Instruction bits 22:21 select the operation: 0 = Rm+Rn, 1 = Rm−Rn, 2 = Rm+2·Rn, 3 = Rm−2·Rn. All other instruction bits outside the decoded fields have no effect on the result.
- R2: A signed add whose true sum exceeds the 32-bit range returns a clamped value. A sum above the range returns 0x7FFFFFFF and a sum below it returns 0x80000000. Otherwise the wrapped sum is returned.
- R3: A signed subtract whose true difference exceeds the 32-bit range returns 0x7FFFFFFF (above the range) or 0x80000000 (below the range). Otherwise the wrapped difference is returned.
- R4: In operations 2 and 3, 2·Rn is first clamped to the 32-bit signed range. The clamped value then enters the final add or subtract, which is clamped again independently.
- R5: The Rd field (bits 15:12) is registered to rd_idx_o. The Rm field (bits 3:0) and the Rn field (bits 19:16) drive rm_idx_o and rn_idx_o combinationally.
- R6: Condition field 0xE (bits 31:28) always executes. Any other code executes only when cond_pass_i is high.
- R7: An accepted instruction whose condition fails gives wr_en_o low. The sticky flag is unchanged and result_o keeps its previous value.
- R8: valid_o is high exactly in the cycle after a cycle with valid_i high. wr_en_o is never high while valid_o is low.
- R9: Any clamping, whether in the doubling step or the final step, of an executed instruction sets the sticky flag. The flag is output on sat_flag_o and on bit 27 of status_o, with all other status bits zero. It stays set until reset.
- R10: While rst_ni is low, valid_o, wr_en_o, sat_flag_o, status_o and result_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction and operands are valid this cycle |
| instr_i | input | 32 | Instruction word |
| cond_pass_i | input | 1 | External condition evaluation result |
| rm_val_i | input | 32 | First operand (Rm value) |
| rn_val_i | input | 32 | Second operand (Rn value) |
| rm_idx_o | output | 4 | Rm register index decoded from instr_i |
| rn_idx_o | output | 4 | Rn register index decoded from instr_i |
| valid_o | output | 1 | Registered result slot is valid |
| wr_en_o | output | 1 | Register write enable |
| rd_idx_o | output | 4 | Destination register index |
| result_o | output | 32 | Saturated result |
| sat_flag_o | output | 1 | Sticky saturation flag |
| status_o | output | 32 | Status word, sticky flag at bit 27 |

## Verification
The hardest case to reach is a doubled operation whose doubling step clamps while the final step does not. In that case only the sticky flag shows that anything happened, because the result looks ordinary. Uniform random operands almost never hit it, so directed cases pair Rn = 0x40000000 with a negative Rm, and each directed case runs from a freshly reset flag. The random phase draws operands from a pool biased toward the range edges and values near ±2^30. This makes doubling overflow common, and it happens alongside random condition codes and pass bits.

// File: rtl/qsat_pkg.sv
package qsat_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned IDX_W      = 4;
  localparam int unsigned COND_W     = 4;
  localparam int unsigned COND_LSB   = 28;
  localparam int unsigned OP_LSB     = 21;
  localparam int unsigned RN_LSB     = 16;
  localparam int unsigned RD_LSB     = 12;
  localparam int unsigned RM_LSB     = 0;
  localparam int unsigned STICKY_BIT = 27;
  localparam logic [COND_W-1:0] COND_ALWAYS = 4'hE;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_DADD = 2'd2,
    OP_DSUB = 2'd3
  } op_e;

  typedef struct packed {
    logic [COND_W-1:0] cond;
    op_e               op;
    logic [IDX_W-1:0]  rn;
    logic [IDX_W-1:0]  rd;
    logic [IDX_W-1:0]  rm;
  } dec_t;
endpackage

// File: rtl/qsat_decode.sv
module qsat_decode
  import qsat_pkg::*;
#(
  parameter int unsigned IW = DATA_W
) (
  input  logic [IW-1:0] instr_i,
  output dec_t          dec_o
);
  always_comb begin
    dec_o.cond = instr_i[COND_LSB +: COND_W];
    dec_o.op   = op_e'(instr_i[OP_LSB +: 2]);
    dec_o.rn   = instr_i[RN_LSB +: IDX_W];
    dec_o.rd   = instr_i[RD_LSB +: IDX_W];
    dec_o.rm   = instr_i[RM_LSB +: IDX_W];
  end
endmodule

// File: rtl/qsat_addsub.sv
module qsat_addsub #(
  parameter int unsigned W = 32
) (
  input  logic         sub_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o,
  output logic         sat_o
);
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MAX_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] raw;
  logic         sa, sb, sr;

  always_comb begin
    raw = sub_i ? (a_i - b_i) : (a_i + b_i);
    sa  = a_i[W-1];
    sb  = b_i[W-1];
    sr  = raw[W-1];
    // add: same-sign inputs, sign flip; sub: opposite-sign inputs, sign flip vs minuend
    sat_o = (sub_i ? (sa != sb) : (sa == sb)) && (sr != sa);
    if (sat_o) y_o = sr ? MAX_POS : MAX_NEG;
    else       y_o = raw;
  end
endmodule

// File: rtl/qsat_core.sv
module qsat_core
  import qsat_pkg::*;
#(
  parameter int unsigned W      = DATA_W,
  parameter bit          DBL_EN = 1'b1
) (
  input  op_e          op_i,
  input  logic [W-1:0] rm_i,
  input  logic [W-1:0] rn_i,
  output logic [W-1:0] y_o,
  output logic         sat_o
);
  logic [W-1:0] rn_eff;
  logic         dbl_sat;
  logic         fin_sat;
  logic         is_sub;

  assign is_sub = (op_i == OP_SUB) || (op_i == OP_DSUB);

  generate
    if (DBL_EN) begin : g_dbl
      logic [W-1:0] dbl_y;
      logic         dbl_s;
      logic         is_dbl;
      assign is_dbl = (op_i == OP_DADD) || (op_i == OP_DSUB);
      qsat_addsub #(.W(W)) u_dbl (
        .sub_i (1'b0),
        .a_i   (rn_i),
        .b_i   (rn_i),
        .y_o   (dbl_y),
        .sat_o (dbl_s)
      );
      assign rn_eff  = is_dbl ? dbl_y : rn_i;
      assign dbl_sat = is_dbl & dbl_s;
    end else begin : g_nodbl
      assign rn_eff  = rn_i;
      assign dbl_sat = 1'b0;
    end
  endgenerate

  qsat_addsub #(.W(W)) u_fin (
    .sub_i (is_sub),
    .a_i   (rm_i),
    .b_i   (rn_eff),
    .y_o   (y_o),
    .sat_o (fin_sat)
  );

  assign sat_o = dbl_sat | fin_sat;
endmodule

// File: rtl/qsat_sticky.sv
module qsat_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
  end
endmodule

// File: rtl/qsat_unit.sv
module qsat_unit
  import qsat_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [W-1:0]     instr_i,
  input  logic             cond_pass_i,
  input  logic [W-1:0]     rm_val_i,
  input  logic [W-1:0]     rn_val_i,
  output logic [IDX_W-1:0] rm_idx_o,
  output logic [IDX_W-1:0] rn_idx_o,
  output logic             valid_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic [W-1:0]     result_o,
  output logic             sat_flag_o,
  output logic [W-1:0]     status_o
);
  dec_t         dec;
  logic [W-1:0] core_y;
  logic         core_sat;
  logic         exec_en;

  qsat_decode #(.IW(W)) u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  assign rm_idx_o = dec.rm;
  assign rn_idx_o = dec.rn;
  assign exec_en  = valid_i && ((dec.cond == COND_ALWAYS) || cond_pass_i);

  qsat_core #(.W(W), .DBL_EN(1'b1)) u_core (
    .op_i  (dec.op),
    .rm_i  (rm_val_i),
    .rn_i  (rn_val_i),
    .y_o   (core_y),
    .sat_o (core_sat)
  );

  qsat_sticky u_sticky (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (exec_en & core_sat),
    .flag_o (sat_flag_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      wr_en_o  <= 1'b0;
      rd_idx_o <= '0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      wr_en_o <= exec_en;
      if (valid_i) rd_idx_o <= dec.rd;
      if (exec_en) result_o <= core_y;
    end
  end

  always_comb begin
    status_o             = '0;
    status_o[STICKY_BIT] = sat_flag_o;
  end
endmodule

// File: rtl/qsat_unit_chk.sv
module qsat_unit_chk
  import qsat_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [W-1:0]     instr_i,
  input logic             cond_pass_i,
  input logic             valid_o,
  input logic             wr_en_o,
  input logic [W-1:0]     result_o,
  input logic             sat_flag_o,
  input logic [W-1:0]     status_o
);
  logic cond_fail;
  assign cond_fail = valid_i && (instr_i[COND_LSB +: COND_W] != COND_ALWAYS) && !cond_pass_i;

  p_valid_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_idle_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_no_wr_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !wr_en_o);
  p_always_exec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[COND_LSB +: COND_W] == COND_ALWAYS) |=> wr_en_o);
  p_cond_fail_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_fail |=> (!wr_en_o && $stable(sat_flag_o) && $stable(result_o)));
  p_sticky_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_flag_o |=> sat_flag_o);
  p_sticky_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sat_flag_o) |-> $past(valid_i));
  p_status_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(status_o) && (status_o[STICKY_BIT] == sat_flag_o));
endmodule

bind qsat_unit qsat_unit_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .instr_i     (instr_i),
  .cond_pass_i (cond_pass_i),
  .valid_o     (valid_o),
  .wr_en_o     (wr_en_o),
  .result_o    (result_o),
  .sat_flag_o  (sat_flag_o),
  .status_o    (status_o)
);

// File: tb/qsat_unit_bench.sv
`timescale 1ns/1ps
module qsat_unit_bench;
  localparam time TCK = 8ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic        cond_pass_i = 1'b0;
  logic [31:0] rm_val_i = '0;
  logic [31:0] rn_val_i = '0;
  logic [3:0]  rm_idx_o, rn_idx_o, rd_idx_o;
  logic        valid_o, wr_en_o, sat_flag_o;
  logic [31:0] result_o, status_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic        exp_flag = 1'b0;
  logic [31:0] exp_res = '0;

  always #(TCK/2) clk_i = ~clk_i;

  qsat_unit u_qsat_unit (
    .clk_i, .rst_ni, .valid_i, .instr_i, .cond_pass_i, .rm_val_i, .rn_val_i,
    .rm_idx_o, .rn_idx_o, .valid_o, .wr_en_o, .rd_idx_o, .result_o,
    .sat_flag_o, .status_o
  );

  function automatic logic [31:0] clamp(input longint v, output bit s);
    s = 1'b0;
    if (v > 64'sd2147483647)       begin s = 1'b1; return 32'h7FFF_FFFF; end
    else if (v < -64'sd2147483648) begin s = 1'b1; return 32'h8000_0000; end
    return v[31:0];
  endfunction

  function automatic logic [31:0] ref_op(input logic [1:0] op, input logic [31:0] rm,
                                         input logic [31:0] rn, output bit s);
    bit s1, s2;
    longint a, b;
    logic [31:0] d;
    a = longint'($signed(rm));
    b = longint'($signed(rn));
    s1 = 1'b0;
    if (op[1]) begin
      d = clamp(2 * b, s1);
      b = longint'($signed(d));
    end
    ref_op = clamp(op[0] ? a - b : a + b, s2);
    s = s1 | s2;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    exp_flag = 1'b0;
    exp_res = '0;
  endtask

  task automatic run_op(input logic [3:0] cond, input bit pass, input logic [1:0] op,
                        input logic [3:0] rd, input logic [31:0] rm, input logic [31:0] rn,
                        input string tag);
    logic [31:0] ins, y;
    bit s, ex;
    @(negedge clk_i);
    ins = $urandom;
    ins[31:28] = cond;
    ins[22:21] = op;
    ins[15:12] = rd;
    instr_i = ins;
    cond_pass_i = pass;
    rm_val_i = rm;
    rn_val_i = rn;
    valid_i = 1'b1;
    #1;
    chk(rm_idx_o == ins[3:0] && rn_idx_o == ins[19:16], "R5 idx", {rm_idx_o, rn_idx_o},
        {ins[3:0], ins[19:16]});
    y = ref_op(op, rm, rn, s);
    ex = (cond == 4'hE) || pass;
    if (ex) begin
      exp_res = y;
      exp_flag = exp_flag | s;
    end
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(valid_o == 1'b1, "R8 valid", 32'(valid_o), 32'd1);
    chk(wr_en_o == ex, {tag, " R6/R7 wr_en"}, 32'(wr_en_o), 32'(ex));
    chk(rd_idx_o == rd, "R5 rd", 32'(rd_idx_o), 32'(rd));
    chk(result_o == exp_res, {tag, " R1/R2/R3/R4 result"}, result_o, exp_res);
    chk(sat_flag_o == exp_flag, {tag, " R9 flag"}, 32'(sat_flag_o), 32'(exp_flag));
    chk(status_o == (32'(exp_flag) << 27), "R9 status", status_o, 32'(exp_flag) << 27);
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 7))
      0: return 32'h7FFF_FFFF - $urandom_range(0, 3);
      1: return 32'h8000_0000 + $urandom_range(0, 3);
      2: return 32'h4000_0000 + $urandom_range(0, 3) - 2;
      3: return 32'hC000_0000 + $urandom_range(0, 3) - 2;
      4: return $urandom_range(0, 15);
      default: return $urandom;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd2024));
    #1;
    chk(valid_o == 0 && wr_en_o == 0 && sat_flag_o == 0 && status_o == 0 && result_o == 0,
        "R10 reset", {valid_o, wr_en_o, sat_flag_o, 29'd0} | result_o | status_o, 32'd0);
    do_reset();
    run_op(4'hE, 0, 2'd0, 4'd1, 32'h7FFF_FFFF, 32'd1, "R2 max+1");
    chk(result_o == 32'h7FFF_FFFF, "R2 clamp hi", result_o, 32'h7FFF_FFFF);
    do_reset();
    run_op(4'hE, 0, 2'd1, 4'd2, 32'h8000_0000, 32'd1, "R3 min-1");
    chk(result_o == 32'h8000_0000, "R3 clamp lo", result_o, 32'h8000_0000);
    do_reset();
    run_op(4'hE, 0, 2'd0, 4'd3, 32'd5, 32'hFFFF_FFFD, "R1 add");
    chk(result_o == 32'd2 && !sat_flag_o, "R1 add plain", result_o, 32'd2);
    run_op(4'hE, 0, 2'd1, 4'd3, 32'd5, 32'd9, "R1 sub");
    chk(result_o == 32'hFFFF_FFFC, "R1 sub plain", result_o, 32'hFFFF_FFFC);
    run_op(4'hE, 0, 2'd2, 4'd4, 32'd0, 32'hC000_0000, "R4 dbl C0");
    chk(result_o == 32'h8000_0000 && !sat_flag_o, "R4 dbl no sat", result_o, 32'h8000_0000);
    run_op(4'hE, 0, 2'd3, 4'd4, 32'd7, 32'd3, "R1 dsub");
    chk(result_o == 32'd1, "R1 dsub plain", result_o, 32'd1);
    do_reset();
    run_op(4'hE, 0, 2'd2, 4'd5, 32'd0, 32'h4000_0000, "R4 dbl 40");
    chk(result_o == 32'h7FFF_FFFF && sat_flag_o, "R4 dbl clamp", result_o, 32'h7FFF_FFFF);
    do_reset();
    // doubling clamps, final add fits: only the flag shows it
    run_op(4'hE, 0, 2'd2, 4'd6, 32'h8000_0000, 32'h4000_0000, "R4 dbl-only");
    chk(result_o == 32'hFFFF_FFFF && sat_flag_o, "R4 dbl-only sat", result_o, 32'hFFFF_FFFF);
    do_reset();
    run_op(4'hE, 0, 2'd0, 4'd7, 32'd10, 32'd20, "R7 prior");
    run_op(4'h0, 0, 2'd0, 4'd8, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R7 cond fail");
    chk(!wr_en_o && !sat_flag_o && result_o == 32'd30, "R7 ignored", result_o, 32'd30);
    run_op(4'h0, 1, 2'd0, 4'd8, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R6 cond pass");
    @(negedge clk_i);
    chk(!valid_o && !wr_en_o, "R8 idle", {30'd0, valid_o, wr_en_o}, 32'd0);
    chk(sat_flag_o, "R9 sticky hold", 32'(sat_flag_o), 32'd1);
    do_reset();
    chk(!sat_flag_o && status_o == 0, "R10 flag clear", status_o, 32'd0);
    for (int i = 0; i < 600; i++) begin
      if (i % 150 == 0) do_reset();
      run_op(($urandom_range(0, 2) == 0) ? 4'hE : 4'($urandom), 1'($urandom),
             2'($urandom), 4'($urandom), pick(), pick(), "rand");
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(TCK * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule